// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Controller

This block gathers 32 private interrupt lines for one processor. Each line is set up to be level-sensitive or edge-triggered. Each line also has an enable bit, an 8-bit priority and a group bit. Every line moves through four states: Idle, Pending, Active, and Active-and-Pending. A priority scan picks the best candidate among lines that are Pending, enabled and below the priority mask. When that best candidate is in group 0 the block raises `fiq_o`. When it is in group 1 the block raises `irq_o`.

Software uses a simple register strobe interface. Reading one of the two acknowledge locations claims an interrupt. The ID the read returns is decided from the state at the moment of the read, not from the state when the request line rose. So a source that has dropped, a line that was disabled, a priority that was lowered, a mask that was tightened, or a higher-priority line of the other group all make the read return the spurious ID 1023. The read never returns a stale ID. Writing an ID to the end-of-interrupt location retires that interrupt. The controller also provides read-only pending and active bitmaps, and a location that reports the current best candidate without claiming it.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset the enable, trigger, group, mask and priority registers hold zero. The pending and active bitmaps are zero, `irq_o` and `fiq_o` are low, and acknowledge and best-candidate reads return 1023.
- R2: A level-sensitive line (trigger bit 0) is Pending while its synchronized source is high. When the source goes low the line leaves the pending condition without any software action: Pending goes to Idle, and Active-and-Pending goes to Active.
- R3: An edge-triggered line (trigger bit 1) becomes Pending on a rising edge of its synchronized source, and stays Pending after the source falls. A rising edge while the line is Active moves it to Active-and-Pending.
- R4: A line is a candidate only when it is in state Pending, its enable bit is 1, and its priority value is strictly less than the mask. The best candidate has the lowest priority value, and ties go to the lowest ID. The best-candidate location (address 7) returns its ID, or 1023 when there is none, and changes no state.
- R5: `fiq_o` is high when the best candidate is in group 0 (group bit 0), and `irq_o` is high when it is in group 1. Both outputs are registered, so they follow the best candidate one cycle later. Both are low when no candidate exists.
- R6: A read of the group-0 acknowledge location (address 4) or the group-1 acknowledge location (address 5) returns the best candidate's ID only when that candidate is in the port's group. The line then moves from Pending to Active. Otherwise the read returns 1023 and no line changes state.
- R7: An acknowledge read returns 1023 when no candidate exists at read time. This covers a level source that has dropped, a line that has been disabled, and a priority raised to the mask value or above.
- R8: An end-of-interrupt write (address 6, ID in bits 9:0) to an Active line moves it to Idle. If the line is Active-and-Pending it moves to Pending instead, and the request output is raised again.
- R9: An end-of-interrupt write that names a line that is not Active or Active-and-Pending, or that names an ID of 32 or more, changes no line state.
- R10: A mask write (address 3) in one cycle applies to an acknowledge read strobed in the very next cycle.
- R11: Read data appears on `rd_data`, together with `rd_valid`, one cycle after `rd_en`. The locations are:
  - enable at 0, trigger at 1, group at 2 and mask at 3, all read/write;
  - pending bitmap at 8 and active bitmap at 9, both read-only;
  - the priority of line n at 0x20+n, read/write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Asynchronous interrupt source lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_o | output | 1 | Group-1 interrupt request |
| fiq_o | output | 1 | Group-0 interrupt request |

## Verification
The assertions check several rules on every cycle:
- a successful acknowledge leaves the returned line active;
- an acknowledge with no candidate returns 1023;
- the two request outputs are never high together, and only follow a real candidate;
- the best candidate always passes the mask;
- level lines drop out of Pending when the source falls;
- an end-of-interrupt write on an Idle line cannot make it active.

Only the bench scenarios can show the orderings that need a history. These are the read-time races that yield the spurious ID, the re-raised request after an end-of-interrupt on Active-and-Pending, tie-breaking by lowest ID, the cross-group spurious result, and a mask write applied on the very next acknowledge.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_ACTPEND = 2'b11
  } line_state_e;

  localparam int              ID_W        = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int              REG_AW      = 6;
  localparam int              REG_DW      = 32;

  localparam logic [REG_AW-1:0] A_ENABLE    = 6'h00;
  localparam logic [REG_AW-1:0] A_TRIG      = 6'h01;
  localparam logic [REG_AW-1:0] A_GROUP     = 6'h02;
  localparam logic [REG_AW-1:0] A_MASK      = 6'h03;
  localparam logic [REG_AW-1:0] A_ACK0      = 6'h04;
  localparam logic [REG_AW-1:0] A_ACK1      = 6'h05;
  localparam logic [REG_AW-1:0] A_EOI       = 6'h06;
  localparam logic [REG_AW-1:0] A_BEST      = 6'h07;
  localparam logic [REG_AW-1:0] A_PENDMAP   = 6'h08;
  localparam logic [REG_AW-1:0] A_ACTMAP    = 6'h09;
  localparam logic [REG_AW-1:0] A_PRIO_BASE = 6'h20;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int NUM_LINES = 32,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] src_i,
  output logic [NUM_LINES-1:0] lvl_o,
  output logic [NUM_LINES-1:0] rise_o
);

  logic [NUM_LINES-1:0] chain_q [STAGES];
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= src_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
  import irq_ack_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        edge_mode_i,
  input  logic        src_lvl_i,
  input  logic        src_rise_i,
  input  logic        ack_take_i,
  input  logic        eoi_take_i,
  output line_state_e state_o
);

  line_state_e state_q, state_d;
  logic        set_ev;
  logic        keep_pend;

  assign set_ev    = edge_mode_i ? src_rise_i : src_lvl_i;
  assign keep_pend = edge_mode_i | src_lvl_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (set_ev) state_d = ST_PEND;
      end
      ST_PEND: begin
        if (ack_take_i)      state_d = (edge_mode_i && src_rise_i) ? ST_ACTPEND : ST_ACT;
        else if (!keep_pend) state_d = ST_IDLE;
      end
      ST_ACT: begin
        if (eoi_take_i)  state_d = set_ev ? ST_PEND : ST_IDLE;
        else if (set_ev) state_d = ST_ACTPEND;
      end
      ST_ACTPEND: begin
        if (eoi_take_i)      state_d = keep_pend ? ST_PEND : ST_IDLE;
        else if (!keep_pend) state_d = ST_ACT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  lvl_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode_i && !src_lvl_i && state_q == ST_PEND && !ack_take_i) |=> state_q == ST_IDLE);

  // R9
  eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_take_i && state_q == ST_IDLE) |=> (state_q != ST_ACT && state_q != ST_ACTPEND));

  // R8
  eoi_repend_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_take_i && state_q == ST_ACTPEND && keep_pend) |=> state_q == ST_PEND);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             qual_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                             vld_o,
  output logic [LINE_W-1:0]                id_o,
  output logic [PRIO_W-1:0]                prio_o
);

  always_comb begin
    vld_o  = 1'b0;
    id_o   = '0;
    prio_o = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (qual_i[i] && (!vld_o || prio_i[i] < prio_o)) begin
        vld_o  = 1'b1;
        id_o   = LINE_W'(i);
        prio_o = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int PRIO_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_src,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [REG_DW-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [REG_DW-1:0]    rd_data,
  output logic                 rd_valid,
  output logic                 irq_o,
  output logic                 fiq_o
);

  localparam int LINE_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0]             en_q, trig_q, grp_q;
  logic [PRIO_W-1:0]                mask_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;

  logic [NUM_LINES-1:0] src_lvl, src_rise;
  logic [NUM_LINES-1:0] ack_hit, eoi_hit;
  logic [NUM_LINES-1:0] pend_vec, act_vec, qual_vec;
  line_state_e          line_st [NUM_LINES];

  logic              best_vld, best_grp;
  logic [LINE_W-1:0] best_id;
  logic [PRIO_W-1:0] best_prio;

  logic              ack_rd0, ack_rd1, ack_rd, ack_take;
  logic              eoi_wr;
  logic [ID_W-1:0]   eoi_id;
  logic [REG_AW-1:0] wr_pidx, rd_pidx;
  logic              prio_wr;
  logic [REG_DW-1:0] rd_next;

  irq_src_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .src_i (irq_src),
    .lvl_o (src_lvl),
    .rise_o(src_rise)
  );

  // configuration registers
  assign wr_pidx = wr_addr - A_PRIO_BASE;
  assign prio_wr = wr_en && (wr_addr >= A_PRIO_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      trig_q <= '0;
      grp_q  <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_ENABLE) en_q   <= wr_data[NUM_LINES-1:0];
      if (wr_en && wr_addr == A_TRIG)   trig_q <= wr_data[NUM_LINES-1:0];
      if (wr_en && wr_addr == A_GROUP)  grp_q  <= wr_data[NUM_LINES-1:0];
      if (wr_en && wr_addr == A_MASK)   mask_q <= wr_data[PRIO_W-1:0];
      for (int i = 0; i < NUM_LINES; i++) begin
        if (prio_wr && wr_pidx == REG_AW'(i)) prio_q[i] <= wr_data[PRIO_W-1:0];
      end
    end
  end

  // acknowledge / end-of-interrupt decode
  assign ack_rd0  = rd_en && (rd_addr == A_ACK0);
  assign ack_rd1  = rd_en && (rd_addr == A_ACK1);
  assign ack_rd   = ack_rd0 || ack_rd1;
  assign best_grp = grp_q[best_id];
  assign ack_take = best_vld && ((ack_rd0 && !best_grp) || (ack_rd1 && best_grp));
  assign eoi_wr   = wr_en && (wr_addr == A_EOI);
  assign eoi_id   = wr_data[ID_W-1:0];

  // per-line lifecycle
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign ack_hit[g] = ack_take && (best_id == LINE_W'(g));
    assign eoi_hit[g] = eoi_wr && (eoi_id == ID_W'(g));

    irq_line_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .edge_mode_i(trig_q[g]),
      .src_lvl_i  (src_lvl[g]),
      .src_rise_i (src_rise[g]),
      .ack_take_i (ack_hit[g]),
      .eoi_take_i (eoi_hit[g]),
      .state_o    (line_st[g])
    );

    assign pend_vec[g] = (line_st[g] == ST_PEND) || (line_st[g] == ST_ACTPEND);
    assign act_vec[g]  = (line_st[g] == ST_ACT)  || (line_st[g] == ST_ACTPEND);
    assign qual_vec[g] = (line_st[g] == ST_PEND) && en_q[g] && (prio_q[g] < mask_q);
  end

  irq_prio_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
    .qual_i(qual_vec),
    .prio_i(prio_q),
    .vld_o (best_vld),
    .id_o  (best_id),
    .prio_o(best_prio)
  );

  // read path
  assign rd_pidx = rd_addr - A_PRIO_BASE;

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_ENABLE:  rd_next = REG_DW'(en_q);
      A_TRIG:    rd_next = REG_DW'(trig_q);
      A_GROUP:   rd_next = REG_DW'(grp_q);
      A_MASK:    rd_next = REG_DW'(mask_q);
      A_ACK0:    rd_next = (best_vld && !best_grp) ? REG_DW'(best_id) : REG_DW'(SPURIOUS_ID);
      A_ACK1:    rd_next = (best_vld &&  best_grp) ? REG_DW'(best_id) : REG_DW'(SPURIOUS_ID);
      A_BEST:    rd_next = best_vld ? REG_DW'(best_id) : REG_DW'(SPURIOUS_ID);
      A_PENDMAP: rd_next = REG_DW'(pend_vec);
      A_ACTMAP:  rd_next = REG_DW'(act_vec);
      default: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (rd_addr >= A_PRIO_BASE && rd_pidx == REG_AW'(i)) rd_next = REG_DW'(prio_q[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      irq_o    <= 1'b0;
      fiq_o    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
      irq_o <= best_vld &&  best_grp;
      fiq_o <= best_vld && !best_grp;
    end
  end

  // R6
  ack_moves_chk: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> (rd_data != REG_DW'(SPURIOUS_ID)) && act_vec[rd_data[LINE_W-1:0]]);

  // R7
  ack_spur_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !best_vld) |=> rd_data == REG_DW'(SPURIOUS_ID));

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && fiq_o));

  // R5
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> $past(|qual_vec));

  // R4
  best_mask_chk: assert property (@(posedge clk) disable iff (rst)
    best_vld |-> (best_prio < mask_q) && en_q[best_id]);

endmodule

// File: tb/tb_irq_ack_ctrl.sv
`timescale 1ns/100ps
module tb_irq_ack_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_src;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [31:0] SPUR = 32'd1023;

  always #2.5 clk = ~clk;

  irq_ack_ctrl dut (
    .clk(clk), .rst(rst), .irq_src(irq_src),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    n_cmp++;
    if (rd_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: rd_valid actual %0b expected 1", rd_valid);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] bits);
    irq_src = irq_src | bits;
    repeat (4) @(negedge clk);
    irq_src = irq_src & ~bits;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 fiq", {31'd0, fiq_o}, 0);
    rd(6'h08, v); chk("R1 pendmap", v, 0);
    rd(6'h09, v); chk("R1 actmap", v, 0);
    rd(6'h03, v); chk("R1 mask", v, 0);
    rd(6'h25, v); chk("R1 prio5", v, 0);
    rd(6'h07, v); chk("R1 best", v, SPUR);
    rd(6'h05, v); chk("R1 ack1", v, SPUR);
  endtask

  task automatic t_config();
    logic [31:0] v;
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h01, (32'd1 << 7) | (32'd1 << 10) | (32'd1 << 12) | (32'd1 << 20));
    wr(6'h02, (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 12));
    wr(6'h03, 32'hFF);
    wr(6'h23, 32'h40);
    wr(6'h27, 32'h30);
    wr(6'h2A, 32'h20);
    wr(6'h2C, 32'h30);
    wr(6'h34, 32'h10);
    rd(6'h00, v); chk("R11 enable", v, 32'hFFFF_FFFF);
    rd(6'h02, v); chk("R11 group", v, 32'h0000_1088);
    rd(6'h03, v); chk("R11 mask", v, 32'hFF);
    rd(6'h2A, v); chk("R11 prio10", v, 32'h20);
  endtask

  task automatic t_level();
    logic [31:0] v;
    irq_src[3] = 1'b1;
    settle();
    chk("R5 irq level", {31'd0, irq_o}, 1);
    chk("R5 fiq level", {31'd0, fiq_o}, 0);
    rd(6'h07, v); chk("R4 best level", v, 3);
    rd(6'h08, v); chk("R4 best read no change", v, 32'h8);
    rd(6'h04, v); chk("R6 ack0 wrong group", v, SPUR);
    rd(6'h09, v); chk("R6 no state change", v, 0);
    rd(6'h05, v); chk("R6 ack1", v, 3);
    settle();
    rd(6'h09, v); chk("R6 active", v, 32'h8);
    rd(6'h08, v); chk("R2 still asserted pending", v, 32'h8);
    chk("R5 irq off while active", {31'd0, irq_o}, 0);
    irq_src[3] = 1'b0;
    settle();
    rd(6'h08, v); chk("R2 drop AP to active", v, 0);
    rd(6'h09, v); chk("R2 active kept", v, 32'h8);
    wr(6'h06, 32'd3);
    settle();
    rd(6'h09, v); chk("R8 eoi to idle", v, 0);
  endtask

  task automatic t_repend_race();
    logic [31:0] v;
    irq_src[3] = 1'b1;
    settle();
    rd(6'h05, v); chk("R6 ack1 again", v, 3);
    settle();
    wr(6'h06, 32'd3);
    settle();
    chk("R8 resignal irq", {31'd0, irq_o}, 1);
    rd(6'h09, v); chk("R8 not active", v, 0);
    rd(6'h08, v); chk("R8 pending", v, 32'h8);
    irq_src[3] = 1'b0;
    settle();
    rd(6'h08, v); chk("R2 pending to idle", v, 0);
    rd(6'h05, v); chk("R7 source dropped", v, SPUR);
    chk("R5 irq low", {31'd0, irq_o}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    pulse(32'd1 << 10);
    rd(6'h08, v); chk("R3 edge pending", v, 32'h400);
    chk("R5 fiq edge", {31'd0, fiq_o}, 1);
    chk("R5 irq edge", {31'd0, irq_o}, 0);
    rd(6'h04, v); chk("R6 ack0", v, 10);
    pulse(32'd1 << 10);
    rd(6'h08, v); chk("R3 AP pending", v, 32'h400);
    rd(6'h09, v); chk("R3 AP active", v, 32'h400);
    chk("R5 fiq off AP", {31'd0, fiq_o}, 0);
    wr(6'h06, 32'd10);
    settle();
    chk("R8 edge resignal fiq", {31'd0, fiq_o}, 1);
    rd(6'h04, v); chk("R8 ack0 again", v, 10);
    wr(6'h06, 32'd10);
    settle();
    rd(6'h09, v); chk("R8 edge idle", v, 0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    pulse((32'd1 << 7) | (32'd1 << 12));
    rd(6'h07, v); chk("R4 tie lowest id", v, 7);
    chk("R5 irq", {31'd0, irq_o}, 1);
    pulse(32'd1 << 20);
    rd(6'h07, v); chk("R4 lower value wins", v, 20);
    chk("R5 fiq g0 best", {31'd0, fiq_o}, 1);
    chk("R5 irq g0 best", {31'd0, irq_o}, 0);
    rd(6'h05, v); chk("R6 other group higher", v, SPUR);
    wr(6'h03, 32'h10);
    rd(6'h04, v); chk("R10 mask next read", v, SPUR);
    rd(6'h09, v); chk("R10 nothing active", v, 0);
    wr(6'h03, 32'hFF);
    wr(6'h00, ~(32'd1 << 20));
    rd(6'h04, v); chk("R7 disabled", v, SPUR);
    rd(6'h05, v); chk("R4 ack1 best 7", v, 7);
    rd(6'h05, v); chk("R4 ack1 next 12", v, 12);
    wr(6'h06, 32'd7);
    wr(6'h06, 32'd12);
    wr(6'h06, 32'd20);
    wr(6'h06, 32'd1000);
    settle();
    rd(6'h09, v); chk("R9 eoi ignored active", v, 0);
    rd(6'h08, v); chk("R9 eoi ignored pending", v, 32'h0010_0000);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h34, 32'hFF);
    rd(6'h04, v); chk("R7 lowered priority", v, SPUR);
    wr(6'h34, 32'h10);
    rd(6'h04, v); chk("R6 ack0 restored", v, 20);
  endtask

  initial begin
    rst = 1'b1; irq_src = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_level();
    t_repend_race();
    t_edge();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule